// File: doc/BRIEF.md
# Split-Carry Pipelined Adder

This block adds two wide operands in two clock stages. Each operand is cut at a parameterised split point into a lower part and an upper part. In the first stage only the lower parts are added. That partial sum and its carry-out are registered, and the upper parts of both operands are registered beside them. In the second stage the upper parts are added together with the registered carry. The result is then joined to the delayed lower sum and registered as the output. The longest carry chain in either stage is therefore only as wide as the wider of the two parts, not the whole operand.

A new operand pair can be presented on every clock, and the pipeline never stalls. A valid flag travels with each pair. A per-pair signedness flag chooses how the upper parts are extended. In two's-complement mode they are sign-extended by one bit. In unsigned mode they are zero-extended. The result is one bit wider than the operands, so it never overflows in either mode. A synchronous reset empties the valid pipe and leaves the data registers alone.

Top module: `split_carry_adder`

## Requirements
- R1: While `rst` is high at a rising edge, and on the edges that follow until a newly accepted pair arrives, `out_valid` is 0.
- R2: `out_valid` is 1 exactly two rising edges after a rising edge that samples `in_valid` high. It is 0 two edges after one that samples `in_valid` low, whatever the operand inputs held then.
- R3: Pairs presented on consecutive cycles produce results on consecutive cycles, in the same order, with no lost or repeated result.
- R4: With `in_signed` = 0, `out_sum` (WIDTH+1 bits) equals the zero-extended sum of `in_a` and `in_b`.
- R5: With `in_signed` = 1, `out_sum` equals the two's-complement sum of `in_a` and `in_b`, each read as a signed WIDTH-bit value, given in WIDTH+1 bits with bit WIDTH as the sign.
- R6: A carry out of the lower LO_WIDTH bits is added into the upper part of the same result; for example 0x00FF + 0x0001 gives 0x00100.
- R7: `out_sum[LO_WIDTH-1:0]` equals (`in_a` + `in_b`) modulo 2^LO_WIDTH for the same pair.
- R8: The signedness flag is taken per pair: back-to-back pairs with different `in_signed` values each use their own flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipe |
| in_valid | input | 1 | Operand pair present this cycle |
| in_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | `out_sum` holds the result of the pair presented two cycles earlier |
| out_sum | output | WIDTH+1 | Registered sum |

## Verification
The adder is driven with fixed corner pairs and then with long pseudo-random streams. The corner pairs are zero, all-ones, the most negative value, largest positive plus one, and lower-half values that produce a carry and values that do not. Running each corner pair in both signedness modes separates zero extension from sign extension in the upper part. It also shows whether the registered carry reaches the right result. Back-to-back streams with the signedness flag alternating check that the flag stays aligned with its data. Gaps in `in_valid` with changing operand values show that the valid flag follows its own two-cycle path and that unaccepted data does not produce a result.

// File: rtl/split_carry_pkg.sv
package split_carry_pkg;

  // Extension bit placed above an upper part before it is added
  function automatic logic ext_bit(input logic msb, input logic is_signed);
    return is_signed & msb;
  endfunction

endpackage

// File: rtl/split_carry_lo_stage.sv
module split_carry_lo_stage #(
  parameter int WIDTH    = 16,
  parameter int LO_WIDTH = 8,
  localparam int HI_WIDTH = WIDTH - LO_WIDTH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_i,
  input  logic                sgn_i,
  input  logic [WIDTH-1:0]    a_i,
  input  logic [WIDTH-1:0]    b_i,
  output logic                v_o,
  output logic                sgn_o,
  output logic                carry_o,
  output logic [LO_WIDTH-1:0] lo_o,
  output logic [HI_WIDTH-1:0] hi_a_o,
  output logic [HI_WIDTH-1:0] hi_b_o
);

  logic [LO_WIDTH:0] lo_full;

  always_comb begin
    lo_full = {1'b0, a_i[LO_WIDTH-1:0]} + {1'b0, b_i[LO_WIDTH-1:0]};
  end

  // valid pipe: the only state cleared by reset
  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
  end

  // data registers, no reset
  always_ff @(posedge clk) begin
    lo_o    <= lo_full[LO_WIDTH-1:0];
    carry_o <= lo_full[LO_WIDTH];
    hi_a_o  <= a_i[WIDTH-1:LO_WIDTH];
    hi_b_o  <= b_i[WIDTH-1:LO_WIDTH];
    sgn_o   <= sgn_i;
  end

  // R2
  lo_valid_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    v_i |=> v_o);

  // R2
  lo_valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !v_i |=> !v_o);

  // R6: carry set exactly when a_lo exceeds the complement of b_lo
  lo_carry_chk: assert property (@(posedge clk) disable iff (rst)
    v_i |=> (carry_o == ($past(a_i[LO_WIDTH-1:0]) > (~$past(b_i[LO_WIDTH-1:0])))));

endmodule

// File: rtl/split_carry_hi_stage.sv
module split_carry_hi_stage
  import split_carry_pkg::*;
#(
  parameter int HI_WIDTH = 8,
  parameter int LO_WIDTH = 8,
  localparam int OUT_W = HI_WIDTH + LO_WIDTH + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_i,
  input  logic                sgn_i,
  input  logic                carry_i,
  input  logic [LO_WIDTH-1:0] lo_i,
  input  logic [HI_WIDTH-1:0] hi_a_i,
  input  logic [HI_WIDTH-1:0] hi_b_i,
  output logic                v_o,
  output logic [OUT_W-1:0]    sum_o
);

  logic [HI_WIDTH:0] hi_full;

  always_comb begin
    hi_full = {ext_bit(hi_a_i[HI_WIDTH-1], sgn_i), hi_a_i}
            + {ext_bit(hi_b_i[HI_WIDTH-1], sgn_i), hi_b_i}
            + {{HI_WIDTH{1'b0}}, carry_i};
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
  end

  // lower sum delayed one register to line up with its upper part
  always_ff @(posedge clk) begin
    sum_o <= {hi_full, lo_i};
  end

  // R2
  hi_valid_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    v_i |=> v_o);

  // R2
  hi_valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !v_i |=> !v_o);

endmodule

// File: rtl/split_carry_adder.sv
module split_carry_adder #(
  parameter int WIDTH    = 16,
  parameter int LO_WIDTH = 8,
  localparam int HI_WIDTH = WIDTH - LO_WIDTH,
  localparam int OUT_W    = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_signed,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_sum
);

  logic                s1_v;
  logic                s1_sgn;
  logic                s1_carry;
  logic [LO_WIDTH-1:0] s1_lo;
  logic [HI_WIDTH-1:0] s1_hi_a;
  logic [HI_WIDTH-1:0] s1_hi_b;

  split_carry_lo_stage #(
    .WIDTH   (WIDTH),
    .LO_WIDTH(LO_WIDTH)
  ) lo_stage_i (
    .clk    (clk),
    .rst    (rst),
    .v_i    (in_valid),
    .sgn_i  (in_signed),
    .a_i    (in_a),
    .b_i    (in_b),
    .v_o    (s1_v),
    .sgn_o  (s1_sgn),
    .carry_o(s1_carry),
    .lo_o   (s1_lo),
    .hi_a_o (s1_hi_a),
    .hi_b_o (s1_hi_b)
  );

  split_carry_hi_stage #(
    .HI_WIDTH(HI_WIDTH),
    .LO_WIDTH(LO_WIDTH)
  ) hi_stage_i (
    .clk    (clk),
    .rst    (rst),
    .v_i    (s1_v),
    .sgn_i  (s1_sgn),
    .carry_i(s1_carry),
    .lo_i   (s1_lo),
    .hi_a_i (s1_hi_a),
    .hi_b_i (s1_hi_b),
    .v_o    (out_valid),
    .sum_o  (out_sum)
  );

  // full-width reference sums used only by the checks below
  logic [OUT_W-1:0]    chk_full;
  logic [LO_WIDTH-1:0] chk_lo;

  always_comb begin
    chk_full = {in_signed & in_a[WIDTH-1], in_a} + {in_signed & in_b[WIDTH-1], in_b};
    chk_lo   = in_a[LO_WIDTH-1:0] + in_b[LO_WIDTH-1:0];
  end

  // R4 R5 R8
  full_sum_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum == $past(chk_full, 2)));

  // R7
  low_part_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum[LO_WIDTH-1:0] == $past(chk_lo, 2)));

  // R2
  end_to_end_valid_chk: assert property (@(posedge clk) disable iff (rst)
    s1_v |=> out_valid);

endmodule

// File: tb/split_carry_adder_tb.sv
module split_carry_adder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int LO_W = 8;
  localparam int OW   = W + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_signed = 1'b0;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic          out_valid;
  logic [OW-1:0] out_sum;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  split_carry_adder #(.WIDTH(W), .LO_WIDTH(LO_W)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_signed(in_signed),
    .in_a     (in_a),
    .in_b     (in_b),
    .out_valid(out_valid),
    .out_sum  (out_sum)
  );

  typedef struct {
    bit            v;
    logic [OW-1:0] s;
    string         tag;
  } exp_t;

  exp_t q[$];

  function automatic logic [OW-1:0] ref_add(bit sg, logic [W-1:0] a, logic [W-1:0] b);
    longint ia, ib;
    ia = sg ? longint'($signed(a)) : longint'(a);
    ib = sg ? longint'($signed(b)) : longint'(b);
    return OW'(ia + ib);
  endfunction

  function automatic exp_t idle_entry(string t);
    exp_t e;
    e.v = 0; e.s = '0; e.tag = t;
    return e;
  endfunction

  initial begin
    q.push_back(idle_entry("R1"));
    q.push_back(idle_entry("R1"));
  end

  // behavioural model: one entry per edge, output trails by one entry
  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      q.delete();
      q.push_back(idle_entry("R1"));
      q.push_back(idle_entry("R1"));
    end else begin
      e.v   = in_valid;
      e.s   = ref_add(in_signed, in_a, in_b);
      e.tag = in_valid ? cur_tag : "R2";
      q.push_back(e);
      while (q.size() > 2) void'(q.pop_front());
    end
  end

  always @(negedge clk) begin
    exp_t e;
    if (!finished) begin
      e = q[0];
      checks++;
      if (out_valid !== e.v) begin
        fails++;
        $display("FAIL %s valid: actual %0b expected %0b at %0t", e.tag, out_valid, e.v, $time);
      end
      if (e.v) begin
        checks++;
        if (out_sum !== e.s) begin
          fails++;
          $display("FAIL %s sum: actual %h expected %h at %0t", e.tag, out_sum, e.s, $time);
        end
        checks++;
        if (out_sum[LO_W-1:0] !== e.s[LO_W-1:0]) begin
          fails++;
          $display("FAIL R7 low part: actual %h expected %h at %0t",
                   out_sum[LO_W-1:0], e.s[LO_W-1:0], $time);
        end
      end
    end
  end

  task automatic put(input bit v, input bit sg, input logic [W-1:0] a,
                     input logic [W-1:0] b, input string t);
    @(negedge clk);
    in_valid  = v;
    in_signed = sg;
    in_a      = a;
    in_b      = b;
    cur_tag   = t;
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] step(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    // R1: reset with valid high on the inputs
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    put(0, 0, '0, '0, "R1");
    rst = 1'b0;
    put(0, 0, 16'hFFFF, 16'hFFFF, "R1");
    put(0, 0, '0, '0, "R1");

    // R4 unsigned corners
    put(1, 0, 16'h0000, 16'h0000, "R4");
    put(1, 0, 16'hFFFF, 16'hFFFF, "R4");
    put(1, 0, 16'h1234, 16'h4321, "R4");
    put(1, 0, 16'h8000, 16'h8000, "R4");
    // R6 carry across the split
    put(1, 0, 16'h00FF, 16'h0001, "R6");
    put(1, 0, 16'h7FFF, 16'h0001, "R6");
    put(1, 1, 16'h7FFF, 16'h0001, "R6");
    put(1, 1, 16'h00FF, 16'hFF01, "R6");
    // R5 signed corners
    put(1, 1, 16'hFFFF, 16'hFFFF, "R5");
    put(1, 1, 16'h8000, 16'h8000, "R5");
    put(1, 1, 16'h8000, 16'h7FFF, "R5");
    put(1, 1, 16'h0080, 16'h0080, "R5");

    // R2: gaps with changing data on the inputs
    for (int i = 0; i < 12; i++) begin
      lfsr = step(lfsr);
      put(bit'(i % 3 == 0), lfsr[0], lfsr[31:16], lfsr[15:0], "R2");
    end

    // R3: long back-to-back stream, unsigned
    for (int i = 0; i < 200; i++) begin
      lfsr = step(lfsr);
      put(1, 0, lfsr[31:16], lfsr[15:0], "R3");
    end

    // R8: back-to-back with signedness alternating
    for (int i = 0; i < 200; i++) begin
      lfsr = step(lfsr);
      put(1, bit'(i % 2), lfsr[31:16], lfsr[15:0], "R8");
    end

    // R1: reset in mid-stream drops pending results
    put(1, 1, 16'h4000, 16'h4000, "R1");
    rst = 1'b1;
    put(1, 0, 16'h0101, 16'h0202, "R1");
    rst = 1'b0;
    put(0, 0, '0, '0, "R1");
    put(1, 1, 16'hFF80, 16'hFF80, "R5");
    put(0, 0, '0, '0, "R2");
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule